// File: doc/BRIEF.md
# Row-Latched Data EEPROM Write Controller

This block sits between a processor's byte bus and a data EEPROM whose cells are grouped in rows of 32 bytes. Software sets a latch-enable bit and then writes one or more bytes of a single row. These bytes land in a row buffer, and the buffer marks each byte that has been written. Software then sets a program bit. The controller runs one programming cycle of fixed length and copies only the marked bytes into the cell array. The other bytes of that row keep their old contents, so a single byte can be updated on its own.

Software finds out when the cycle has ended by polling the program bit until it reads 0. At that point the hardware has also dropped latch-enable and cleared the row buffer. Reads of the EEPROM window return cell contents only while the controller is idle with latch-enable clear. At all other times they return zero. The cell array is a register model, and the length of the programming cycle is a parameter.

Top module: `rowlatch_eectl`

## Requirements
- R1: After reset the control/status register reads 0x00 and every byte of the EEPROM window reads 0x00.
- R2: A window write made while latch-enable (control bit 1) is set goes into the row buffer. The cells do not change until a programming cycle commits the buffer.
- R3: Writing the control register with bits 1 and 0 both set starts programming when latch-enable is already set and at least one byte is buffered. Bit 0 then reads 1 for exactly PROG_CYCLES clock cycles and afterwards reads 0.
- R4: A programming cycle writes only the buffered bytes of the captured row. Every other byte of that row, and of every other row, keeps its value.
- R5: The programming cycle has the same length whether 1 byte or all 32 bytes of a row are buffered.
- R6: The first buffered write fixes the row, which is the address bits above the low 5. Later buffered writes to any other row are ignored until the buffer is cleared.
- R7: When programming ends, the controller clears the row buffer and latch-enable, and the control register reads 0x00.
- R8: Setting bit 0 while latch-enable is clear, or while no byte is buffered, starts nothing. Bit 0 reads back 0.
- R9: While latch-enable is set or programming is in progress, window reads return 0x00.
- R10: While programming is in progress, window writes and control register writes are ignored.
- R11: A window write made while latch-enable is clear changes nothing.
- R12: Clearing latch-enable without setting bit 0 discards every buffered byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| csr_we | input | 1 | Control/status register write strobe |
| csr_wdata | input | 8 | Control write data: bit 1 latch-enable, bit 0 program |
| csr_rdata | output | 8 | Control/status read data: bit 1 latch-enable, bit 0 busy/program |
| mem_we | input | 1 | EEPROM window byte write strobe |
| mem_addr | input | ADDR_W | Window byte address, used for both writes and reads |
| mem_wdata | input | DATA_W | Window write data |
| mem_rdata | output | DATA_W | Window read data, combinational |

## Verification
Suppose a byte flag is stuck or a row capture is wrong. The error stays hidden while latch-enable is set, because reads are gated to zero. It first shows up at the port on the read-back after the program bit drops. Either a neighbouring byte has changed or the intended byte is missing. A miscounted programming cycle shows up at once, as a difference in how many cycles bit 0 stays high, and that count is compared between a one-byte commit and a full-row commit. A start that should have been refused shows up on the next control read, because bit 0 then reads 1.

// File: rtl/rowlatch_pkg.sv
package rowlatch_pkg;
  localparam int CSR_PROG_BIT  = 0;
  localparam int CSR_LATCH_BIT = 1;

  function automatic logic [7:0] csr_word(input logic latch_en, input logic busy);
    logic [7:0] w;
    w = '0;
    w[CSR_LATCH_BIT] = latch_en;
    w[CSR_PROG_BIT]  = busy;
    return w;
  endfunction

  function automatic logic start_ok(input logic wr_prog, input logic wr_latch,
                                    input logic latch_en, input logic any_buffered);
    return wr_prog & wr_latch & latch_en & any_buffered;
  endfunction
endpackage

// File: rtl/rl_row_latch.sv
module rl_row_latch #(
  parameter int DATA_W    = 8,
  parameter int ROW_BYTES = 32,
  parameter int ROW_W     = 2,
  parameter int OFF_W     = 5
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               wr_en,
  input  logic [ROW_W-1:0]                   wr_row,
  input  logic [OFF_W-1:0]                   wr_off,
  input  logic [DATA_W-1:0]                  wr_data,
  input  logic                               clear,
  output logic [ROW_BYTES-1:0]               flags,
  output logic [ROW_BYTES-1:0][DATA_W-1:0]   data,
  output logic [ROW_W-1:0]                   row_q,
  output logic                               any_flag,
  output logic                               accept
);
  assign any_flag = |flags;
  assign accept   = wr_en & (~any_flag | (wr_row == row_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      row_q <= '0;
    end else if (clear) begin
      flags <= '0;
    end else if (accept) begin
      flags[wr_off] <= 1'b1;
      if (!any_flag) row_q <= wr_row;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data <= '0;
    else if (accept && !clear) data[wr_off] <= wr_data;
  end
endmodule

// File: rtl/rl_prog_seq.sv
module rl_prog_seq #(
  parameter int PROG_CYCLES = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CNT_W = $clog2(PROG_CYCLES + 1);
  logic [CNT_W-1:0] remain;

  assign done = busy & (remain == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      remain <= '0;
    end else if (!busy) begin
      if (start) begin
        busy   <= 1'b1;
        remain <= CNT_W'(PROG_CYCLES - 1);
      end
    end else if (done) begin
      busy <= 1'b0;
    end else begin
      remain <= remain - 1'b1;
    end
  end
endmodule

// File: rtl/rl_cell_array.sv
module rl_cell_array #(
  parameter int DATA_W    = 8,
  parameter int ROW_BYTES = 32,
  parameter int ROW_W     = 2,
  parameter int ADDR_W    = 7
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             commit,
  input  logic [ROW_W-1:0]                 commit_row,
  input  logic [ROW_BYTES-1:0]             flags,
  input  logic [ROW_BYTES-1:0][DATA_W-1:0] data,
  input  logic [ADDR_W-1:0]                rd_addr,
  output logic [DATA_W-1:0]                rd_data
);
  localparam int ROWS  = 1 << ROW_W;
  localparam int WORDS = ROWS * ROW_BYTES;

  logic [DATA_W-1:0] words [WORDS];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    localparam logic [ROW_W-1:0] RID = ROW_W'(r);
    logic row_sel;
    assign row_sel = commit & (commit_row == RID);
    for (genvar b = 0; b < ROW_BYTES; b++) begin : g_byte
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else if (row_sel && flags[b]) q <= data[b];
      end
      assign words[r*ROW_BYTES + b] = q;
    end
  end

  assign rd_data = words[rd_addr];
endmodule

// File: rtl/rowlatch_eectl.sv
module rowlatch_eectl #(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 7,
  parameter int ROW_BYTES   = 32,
  parameter int PROG_CYCLES = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_we,
  input  logic [7:0]        csr_wdata,
  output logic [7:0]        csr_rdata,
  input  logic              mem_we,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_wdata,
  output logic [DATA_W-1:0] mem_rdata
);
  import rowlatch_pkg::*;

  localparam int OFF_W = $clog2(ROW_BYTES);
  localparam int ROW_W = ADDR_W - OFF_W;

  logic                             le_q;
  logic                             busy;
  logic                             done;
  logic                             start;
  logic                             csr_ok;
  logic                             lat_wr;
  logic                             lat_clr;
  logic                             lat_accept;
  logic                             any_flag;
  logic [ROW_W-1:0]                 row_q;
  logic [ROW_BYTES-1:0]             flags;
  logic [ROW_BYTES-1:0][DATA_W-1:0] lat_data;
  logic [DATA_W-1:0]                cell_rd;

  assign csr_ok  = csr_we & ~busy;
  assign start   = csr_ok & start_ok(csr_wdata[CSR_PROG_BIT], csr_wdata[CSR_LATCH_BIT],
                                     le_q, any_flag);
  assign lat_wr  = mem_we & le_q & ~busy;
  assign lat_clr = done | (csr_ok & ~csr_wdata[CSR_LATCH_BIT]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      le_q <= 1'b0;
    else if (done)   le_q <= 1'b0;
    else if (csr_ok) le_q <= csr_wdata[CSR_LATCH_BIT];
  end

  rl_row_latch #(
    .DATA_W(DATA_W), .ROW_BYTES(ROW_BYTES), .ROW_W(ROW_W), .OFF_W(OFF_W)
  ) u_latch (
    .clk(clk), .rst_n(rst_n),
    .wr_en(lat_wr),
    .wr_row(mem_addr[ADDR_W-1:OFF_W]),
    .wr_off(mem_addr[OFF_W-1:0]),
    .wr_data(mem_wdata),
    .clear(lat_clr),
    .flags(flags), .data(lat_data), .row_q(row_q),
    .any_flag(any_flag), .accept(lat_accept)
  );

  rl_prog_seq #(.PROG_CYCLES(PROG_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done)
  );

  rl_cell_array #(
    .DATA_W(DATA_W), .ROW_BYTES(ROW_BYTES), .ROW_W(ROW_W), .ADDR_W(ADDR_W)
  ) u_cells (
    .clk(clk), .rst_n(rst_n),
    .commit(done), .commit_row(row_q), .flags(flags), .data(lat_data),
    .rd_addr(mem_addr), .rd_data(cell_rd)
  );

  assign csr_rdata = csr_word(le_q, busy);
  assign mem_rdata = (le_q | busy) ? '0 : cell_rd;
endmodule

// File: rtl/rowlatch_eectl_chk.sv
module rowlatch_eectl_chk #(
  parameter int PROG_CYCLES = 200,
  parameter int ROW_W       = 2,
  parameter int DATA_W      = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              le_q,
  input logic              busy,
  input logic              done,
  input logic              any_flag,
  input logic [ROW_W-1:0]  row_q,
  input logic [DATA_W-1:0] mem_rdata
);
  int unsigned busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_cnt <= 0;
    else if (busy) busy_cnt <= busy_cnt + 1;
    else           busy_cnt <= 0;
  end

  p_start_needs_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(le_q) && $past(any_flag));

  p_prog_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy_cnt == PROG_CYCLES - 1);

  p_end_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy && !le_q && !any_flag);

  p_read_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (le_q || busy) |-> mem_rdata == '0);

  p_row_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (any_flag && !done) |=> (!any_flag || $stable(row_q)));

  p_busy_keeps_latch_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> le_q && any_flag);
endmodule

bind rowlatch_eectl rowlatch_eectl_chk #(
  .PROG_CYCLES(PROG_CYCLES), .ROW_W(ROW_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .le_q(le_q), .busy(busy), .done(done),
  .any_flag(any_flag), .row_q(row_q), .mem_rdata(mem_rdata)
);

// File: tb/rowlatch_eectl_bench.sv
module rowlatch_eectl_bench;
  localparam int PC    = 12;
  localparam int AW    = 7;
  localparam int WORDS = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          csr_we = 1'b0;
  logic [7:0]    csr_wdata = '0;
  logic [7:0]    csr_rdata;
  logic          mem_we = 1'b0;
  logic [AW-1:0] mem_addr = '0;
  logic [7:0]    mem_wdata = '0;
  logic [7:0]    mem_rdata;

  int checks = 0;
  int errors = 0;
  logic [7:0] model [WORDS];

  always #4 clk = ~clk;

  rowlatch_eectl #(.DATA_W(8), .ADDR_W(AW), .ROW_BYTES(32), .PROG_CYCLES(PC)) u_rowlatch_eectl (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic mem_write(input int a, input logic [7:0] d);
    @(negedge clk);
    mem_we = 1'b1; mem_addr = AW'(a); mem_wdata = d;
    @(negedge clk);
    mem_we = 1'b0;
  endtask

  task automatic csr_write(input logic [7:0] v);
    @(negedge clk);
    csr_we = 1'b1; csr_wdata = v;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic mem_read(input int a, output logic [7:0] d);
    mem_addr = AW'(a);
    #1;
    d = mem_rdata;
  endtask

  task automatic program_and_time(output int n);
    csr_write(8'h03);
    n = 0;
    while (csr_rdata[0] && n < 10000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic verify_all(input string req);
    int bad = 0;
    logic [7:0] d;
    int first_a = -1;
    for (int a = 0; a < WORDS; a++) begin
      mem_read(a, d);
      if (d != model[a]) begin
        bad++;
        if (first_a < 0) first_a = a;
      end
    end
    chk(req, bad, 0);
    if (bad != 0) $display("  first mismatch at address %0h", first_a);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R1 csr after reset", csr_rdata, 0);
    mem_read(0, d);
    chk("R1 window byte 0 after reset", d, 0);
    verify_all("R1 whole window zero");
  endtask

  task automatic t_full_then_single;
    int n;
    logic [7:0] d;
    csr_write(8'h02);
    chk("R2 latch-enable reads back", csr_rdata, 8'h02);
    for (int i = 0; i < 32; i++) begin
      mem_write(32 + i, 8'(8'hA0 + i));
      model[32 + i] = 8'(8'hA0 + i);
    end
    mem_read(33, d);
    chk("R9 read gated while latch-enable", d, 0);
    program_and_time(n);
    chk("R3 R5 busy length full row", n, PC);
    chk("R7 csr after full row", csr_rdata, 0);
    verify_all("R4 full row committed");
    csr_write(8'h02);
    mem_write(35, 8'h3C);
    model[35] = 8'h3C;
    program_and_time(n);
    chk("R5 busy length single byte", n, PC);
    mem_read(35, d);
    chk("R4 single byte updated", d, 8'h3C);
    mem_read(36, d);
    chk("R4 neighbour byte kept", d, 8'hA4);
    verify_all("R4 single byte update rest unchanged");
  endtask

  task automatic t_other_row;
    int n;
    logic [7:0] d;
    csr_write(8'h02);
    mem_write(64, 8'h77);
    model[64] = 8'h77;
    mem_write(1, 8'h99);
    mem_write(97, 8'h55);
    program_and_time(n);
    chk("R3 program completes", n, PC);
    mem_read(64, d);
    chk("R6 captured row written", d, 8'h77);
    mem_read(1, d);
    chk("R6 other row write ignored", d, 0);
    verify_all("R6 window after row capture");
  endtask

  task automatic t_no_effect;
    csr_write(8'h01);
    chk("R8 program without latch-enable", csr_rdata, 0);
    csr_write(8'h02);
    csr_write(8'h03);
    chk("R8 program with empty buffer", csr_rdata, 8'h02);
    csr_write(8'h00);
    chk("R12 latch-enable cleared", csr_rdata, 0);
    mem_write(5, 8'hEE);
    verify_all("R11 write with latch-enable clear ignored");
  endtask

  task automatic t_busy_ignores;
    int n;
    logic [7:0] d;
    csr_write(8'h02);
    mem_write(96, 8'h12);
    model[96] = 8'h12;
    csr_write(8'h03);
    mem_write(97, 8'hF0);
    mem_read(96, d);
    chk("R9 read gated while busy", d, 0);
    csr_write(8'h00);
    chk("R10 csr write during busy ignored", csr_rdata, 8'h03);
    n = 0;
    while (csr_rdata[0] && n < 10000) begin
      n++;
      @(negedge clk);
    end
    chk("R7 csr cleared after program", csr_rdata, 0);
    mem_read(97, d);
    chk("R10 write during busy ignored", d, 0);
    mem_read(96, d);
    chk("R3 committed byte", d, 8'h12);
  endtask

  task automatic t_discard;
    int n;
    logic [7:0] d;
    csr_write(8'h02);
    mem_write(7, 8'h5A);
    csr_write(8'h00);
    mem_read(7, d);
    chk("R2 R12 cells untouched after discard", d, 0);
    csr_write(8'h02);
    mem_write(8, 8'hC3);
    model[8] = 8'hC3;
    program_and_time(n);
    mem_read(7, d);
    chk("R12 discarded byte not programmed", d, 0);
    mem_read(8, d);
    chk("R12 new byte programmed", d, 8'hC3);
    verify_all("R12 window after discard");
  endtask

  initial begin
    for (int a = 0; a < WORDS; a++) model[a] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_then_single();
    t_other_row();
    t_no_effect();
    t_busy_ignores();
    t_discard();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R3 watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule